// File: doc/BRIEF.md
# Ambient Light Threshold Persistence Interrupt Unit

This block watches the stream of 16-bit visible-light results coming out of a light-sensing front end. Each result that arrives with its valid strobe is compared against a programmable lower bound and upper bound. A run of consecutive results outside that window is counted, and once the run length reaches the target chosen by a 4-bit persistence code, a sticky threshold flag is raised. A second sticky flag records analog saturation reported alongside a result. Each flag can be routed to an active-low interrupt request through its own enable bit.

Software programs each bound one byte at a time: the lower-order byte is parked in a holding register and the full 16-bit bound only changes when the upper-order byte is written, so the comparator never sees a half-updated bound. Flags are cleared by writing ones to their status bit positions, or, if the read-clear option is on, by any status read. Register decoding and the bus are outside this block; it receives one write strobe per register and a shared write data byte.

Top module: `als_thr_irq`

## Requirements
- R1: After reset the status byte is 0x00, the interrupt output is high, both bounds are 0 and the persistence code is 0.
- R2: Writing the lower-order byte of a bound does not change the bound used for comparison; the upper-order byte write sets the bound to {written byte, held byte} in one step.
- R3: A result is out of range only when it is strictly below the lower bound or strictly above the upper bound; a result equal to either bound is in range.
- R4: With persistence code 0 the threshold flag (status bit 4) sets on every valid result, in range or not.
- R5: Codes 1, 2 and 3 set the threshold flag on the 1st, 2nd and 3rd consecutive out-of-range result respectively.
- R6: A code c from 4 to 15 sets the threshold flag on consecutive out-of-range result number 5*(c-3), so code 4 needs 5 and code 15 needs 60.
- R7: An in-range result restarts the consecutive count from zero.
- R8: The threshold flag stays set until cleared even if results return to range; the run count holds at its target, so after a clear the next out-of-range result sets the flag again at once.
- R9: A status write clears the threshold flag when data bit 4 is 1 and the saturation flag (status bit 7) when data bit 7 is 1; a 0 leaves the flag as it is.
- R10: When the read-clear option (configuration write, data bit 7) is on, a status read clears both flags; when it is off, a status read changes nothing.
- R11: A valid result accompanied by the saturation input sets status bit 7.
- R12: The interrupt output is low exactly when (threshold flag and enable bit 4) or (saturation flag and enable bit 7) holds, the enables taken from the interrupt-enable write.
- R13: When a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | A new result is present this cycle |
| res_data | input | 2*BYTE_W | Visible-channel result |
| res_sat | input | 1 | Analog saturation seen with this result |
| wr_data | input | BYTE_W | Shared write data byte |
| wr_lo_lsb | input | 1 | Write lower bound, low-order byte (held) |
| wr_lo_msb | input | 1 | Write lower bound, high-order byte (commits) |
| wr_hi_lsb | input | 1 | Write upper bound, low-order byte (held) |
| wr_hi_msb | input | 1 | Write upper bound, high-order byte (commits) |
| wr_pers | input | 1 | Write persistence code from data bits 3:0 |
| wr_inten | input | 1 | Write enables: bit 4 threshold, bit 7 saturation |
| wr_cfg | input | 1 | Write read-clear option from data bit 7 |
| wr_status | input | 1 | Write-one-to-clear of status bits 4 and 7 |
| rd_status | input | 1 | A status read occurs this cycle |
| status | output | BYTE_W | Bit 7 saturation flag, bit 4 threshold flag, others 0 |
| int_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its default parameters, an 8-bit byte and a 4-bit persistence code, so the full code range is live and the largest run target of 60 results is reached in a few dozen cycles. That makes the exact firing count of every code class reachable, including the non-linear upper codes, alongside the atomic bound commit, the strict-inequality edges of the window and the set-versus-clear collision. A behavioural model in the bench follows every write and result and is compared against status and interrupt on each clock.

// File: rtl/als_thr_pkg.sv
package als_thr_pkg;

  // status and control bit positions (decoded by software)
  localparam int unsigned STAT_THR_BIT = 4;
  localparam int unsigned STAT_SAT_BIT = 7;
  localparam int unsigned EN_THR_BIT   = 4;
  localparam int unsigned EN_SAT_BIT   = 7;
  localparam int unsigned RDCLR_BIT    = 7;

  // run length needed by a persistence code
  function automatic int unsigned pers_target(input int unsigned code);
    if (code <= 3) return code;
    return 5 * (code - 3);
  endfunction

  // strict window test
  function automatic logic outside_window(input logic [31:0] val,
                                          input logic [31:0] lo,
                                          input logic [31:0] hi);
    return (val < lo) || (val > hi);
  endfunction

endpackage

// File: rtl/als_thr_split_reg.sv
module als_thr_split_reg #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lsb,
  input  logic                wr_msb,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic [2*BYTE_W-1:0] value
);
  logic [BYTE_W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      value  <= '0;
    end else begin
      if (wr_lsb) held_q <= wr_data;
      if (wr_msb) value  <= {wr_data, held_q};
    end
  end
endmodule

// File: rtl/als_thr_persist.sv
module als_thr_persist #(
  parameter int unsigned PCODE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               res_valid,
  input  logic               out_of_range,
  input  logic [PCODE_W-1:0] pcode,
  output logic               fire
);
  import als_thr_pkg::*;

  localparam int unsigned MAX_TGT = pers_target((1 << PCODE_W) - 1);
  localparam int unsigned CNT_W   = $clog2(MAX_TGT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_inc, target;

  assign target  = CNT_W'(pers_target(32'(pcode)));
  // hold at target so a held flag never sees a wrapped count
  assign cnt_inc = (cnt_q < target) ? cnt_q + 1'b1 : cnt_q;
  assign fire    = res_valid && ((pcode == '0) || (out_of_range && (cnt_inc >= target)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (res_valid) cnt_q <= out_of_range ? cnt_inc : '0;
  end
endmodule

// File: rtl/als_thr_flags.sv
module als_thr_flags #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_thr,
  input  logic              set_sat,
  input  logic              wclr_thr,
  input  logic              wclr_sat,
  input  logic              rd_clear,
  input  logic              en_thr,
  input  logic              en_sat,
  output logic [BYTE_W-1:0] status,
  output logic              int_n
);
  import als_thr_pkg::*;

  logic thr_q, sat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= 1'b0;
      sat_q <= 1'b0;
    end else begin
      if (set_thr)                    thr_q <= 1'b1;
      else if (wclr_thr || rd_clear)  thr_q <= 1'b0;
      if (set_sat)                    sat_q <= 1'b1;
      else if (wclr_sat || rd_clear)  sat_q <= 1'b0;
    end
  end

  always_comb begin
    status               = '0;
    status[STAT_THR_BIT] = thr_q;
    status[STAT_SAT_BIT] = sat_q;
  end

  assign int_n = ~((thr_q & en_thr) | (sat_q & en_sat));
endmodule

// File: rtl/als_thr_irq.sv
module als_thr_irq #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned PCODE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                res_valid,
  input  logic [2*BYTE_W-1:0] res_data,
  input  logic                res_sat,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                wr_lo_lsb,
  input  logic                wr_lo_msb,
  input  logic                wr_hi_lsb,
  input  logic                wr_hi_msb,
  input  logic                wr_pers,
  input  logic                wr_inten,
  input  logic                wr_cfg,
  input  logic                wr_status,
  input  logic                rd_status,
  output logic [BYTE_W-1:0]   status,
  output logic                int_n
);
  import als_thr_pkg::*;

  localparam int unsigned DATA_W = 2 * BYTE_W;
  localparam int unsigned N_BND  = 2;  // index 0 lower, 1 upper

  logic [N_BND-1:0]  lsb_stb, msb_stb;
  logic [DATA_W-1:0] bound [N_BND];
  logic [PCODE_W-1:0] pcode_q;
  logic en_thr_q, en_sat_q, rdclr_q;

  // named internal events
  logic res_outside, thr_fire, sat_event, rd_clear;

  assign lsb_stb = {wr_hi_lsb, wr_lo_lsb};
  assign msb_stb = {wr_hi_msb, wr_lo_msb};

  for (genvar b = 0; b < N_BND; b++) begin : g_bound
    als_thr_split_reg #(.BYTE_W(BYTE_W)) i_bound (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lsb  (lsb_stb[b]),
      .wr_msb  (msb_stb[b]),
      .wr_data (wr_data),
      .value   (bound[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcode_q  <= '0;
      en_thr_q <= 1'b0;
      en_sat_q <= 1'b0;
      rdclr_q  <= 1'b0;
    end else begin
      if (wr_pers) pcode_q <= wr_data[PCODE_W-1:0];
      if (wr_inten) begin
        en_thr_q <= wr_data[EN_THR_BIT];
        en_sat_q <= wr_data[EN_SAT_BIT];
      end
      if (wr_cfg) rdclr_q <= wr_data[RDCLR_BIT];
    end
  end

  assign res_outside = outside_window(32'(res_data), 32'(bound[0]), 32'(bound[1]));
  assign sat_event   = res_valid && res_sat;
  assign rd_clear    = rd_status && rdclr_q;

  als_thr_persist #(.PCODE_W(PCODE_W)) i_persist (
    .clk          (clk),
    .rst_n        (rst_n),
    .res_valid    (res_valid),
    .out_of_range (res_outside),
    .pcode        (pcode_q),
    .fire         (thr_fire)
  );

  als_thr_flags #(.BYTE_W(BYTE_W)) i_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_thr  (thr_fire),
    .set_sat  (sat_event),
    .wclr_thr (wr_status && wr_data[STAT_THR_BIT]),
    .wclr_sat (wr_status && wr_data[STAT_SAT_BIT]),
    .rd_clear (rd_clear),
    .en_thr   (en_thr_q),
    .en_sat   (en_sat_q),
    .status   (status),
    .int_n    (int_n)
  );
endmodule

// File: rtl/als_thr_irq_chk.sv
module als_thr_irq_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              thr_fire,
  input logic              sat_event,
  input logic              rd_clear,
  input logic              wr_status,
  input logic              clr_thr_bit,
  input logic [BYTE_W-1:0] status,
  input logic              int_n
);
  localparam int unsigned TB = als_thr_pkg::STAT_THR_BIT;
  localparam int unsigned SB = als_thr_pkg::STAT_SAT_BIT;

  logic [BYTE_W-1:0] spare_mask;
  always_comb begin
    spare_mask     = '1;
    spare_mask[TB] = 1'b0;
    spare_mask[SB] = 1'b0;
  end

  assert_spare_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (status & spare_mask) == '0);

  assert_fire_sets_R13: assert property (@(posedge clk) disable iff (!rst_n)
    thr_fire |=> status[TB]);

  assert_sat_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sat_event |=> status[SB]);

  assert_thr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[TB] && !wr_status && !rd_clear) |=> status[TB]);

  assert_wclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && clr_thr_bit && !thr_fire) |=> !status[TB]);

  assert_rdclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !thr_fire && !sat_event) |=> (status == '0));

  assert_int_needs_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> (status[TB] || status[SB]));
endmodule

bind als_thr_irq als_thr_irq_chk #(.BYTE_W(BYTE_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .thr_fire    (thr_fire),
  .sat_event   (sat_event),
  .rd_clear    (rd_clear),
  .wr_status   (wr_status),
  .clr_thr_bit (wr_data[als_thr_pkg::STAT_THR_BIT]),
  .status      (status),
  .int_n       (int_n)
);

// File: tb/test_als_thr_irq.sv
module test_als_thr_irq;
  localparam int BYTE_W = 8;
  localparam int PCODE_W = 4;

  logic clk = 0, rst_n = 0;
  logic res_valid = 0, res_sat = 0;
  logic [15:0] res_data = 0;
  logic [7:0] wr_data = 0;
  logic wr_lo_lsb = 0, wr_lo_msb = 0, wr_hi_lsb = 0, wr_hi_msb = 0;
  logic wr_pers = 0, wr_inten = 0, wr_cfg = 0, wr_status = 0, rd_status = 0;
  logic [7:0] status;
  logic int_n;

  always #5 clk = ~clk;

  als_thr_irq #(.BYTE_W(BYTE_W), .PCODE_W(PCODE_W)) i_als_thr_irq (
    .clk, .rst_n, .res_valid, .res_data, .res_sat, .wr_data,
    .wr_lo_lsb, .wr_lo_msb, .wr_hi_lsb, .wr_hi_msb, .wr_pers,
    .wr_inten, .wr_cfg, .wr_status, .rd_status, .status, .int_n);

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference model state
  int m_lo = 0, m_hi = 0, m_lo_h = 0, m_hi_h = 0, m_code = 0, m_run = 0;
  bit m_thr = 0, m_sat = 0, m_en_t = 0, m_en_s = 0, m_rdc = 0;

  function automatic int need(int code);
    int t = 0;
    if (code < 4) return code;
    for (int k = 4; k <= code; k++) t += 5;
    return t;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_step();
    bit outr, fire, clr_t, clr_s;
    int prev_run;
    outr = (int'(res_data) < m_lo) || (int'(res_data) > m_hi);
    prev_run = m_run;
    fire = 0;
    if (res_valid) begin
      if (outr) begin
        m_run = (prev_run < need(m_code)) ? prev_run + 1 : prev_run;
        if (m_run >= need(m_code)) fire = 1;
      end else m_run = 0;
      if (m_code == 0) fire = 1;
    end
    clr_t = (wr_status && wr_data[4]) || (rd_status && m_rdc);
    clr_s = (wr_status && wr_data[7]) || (rd_status && m_rdc);
    if (fire) m_thr = 1; else if (clr_t) m_thr = 0;
    if (res_valid && res_sat) m_sat = 1; else if (clr_s) m_sat = 0;
    if (wr_lo_lsb) m_lo_h = int'(wr_data);
    if (wr_lo_msb) m_lo = int'(wr_data) * 256 + m_lo_h;
    if (wr_hi_lsb) m_hi_h = int'(wr_data);
    if (wr_hi_msb) m_hi = int'(wr_data) * 256 + m_hi_h;
    if (wr_pers) m_code = int'(wr_data[3:0]);
    if (wr_inten) begin m_en_t = wr_data[4]; m_en_s = wr_data[7]; end
    if (wr_cfg) m_rdc = wr_data[7];
  endtask

  function automatic int exp_status();
    return (m_sat ? 8'h80 : 8'h00) | (m_thr ? 8'h10 : 8'h00);
  endfunction

  function automatic int exp_int();
    return ((m_thr && m_en_t) || (m_sat && m_en_s)) ? 0 : 1;
  endfunction

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check({cur_req, " status"}, int'(status), exp_status());
    check({cur_req, " int_n"}, int'(int_n), exp_int());
    res_valid = 0; res_sat = 0;
    wr_lo_lsb = 0; wr_lo_msb = 0; wr_hi_lsb = 0; wr_hi_msb = 0;
    wr_pers = 0; wr_inten = 0; wr_cfg = 0; wr_status = 0; rd_status = 0;
  endtask

  task automatic meas(int val, bit sat = 0);
    res_valid = 1; res_data = 16'(val); res_sat = sat; tick();
  endtask

  task automatic wreg(string which, int val);
    wr_data = 8'(val);
    case (which)
      "lo_l": wr_lo_lsb = 1;
      "lo_h": wr_lo_msb = 1;
      "hi_l": wr_hi_lsb = 1;
      "hi_h": wr_hi_msb = 1;
      "pers": wr_pers = 1;
      "en":   wr_inten = 1;
      "cfg":  wr_cfg = 1;
      default: wr_status = 1;
    endcase
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 status", int'(status), 0);
    check("R1 int_n", int'(int_n), 1);
    rst_n = 1;
    tick();

    // R4 code 0 fires even in range (bounds 0/0, value 0 in range)
    cur_req = "R4";
    wreg("en", 8'h10);
    meas(0);
    check("R4 flag on in-range", int'(status), 8'h10);
    check("R12 int low", int'(int_n), 0);
    cur_req = "R9";
    wreg("st", 8'h80);
    check("R9 wrong bit keeps flag", int'(status), 8'h10);
    wreg("st", 8'h10);
    check("R9 clear thr", int'(status), 8'h00);

    // R2 atomic bound update
    cur_req = "R2";
    wreg("pers", 1);
    wreg("hi_l", 8'hFF);
    meas(16'h0100);
    check("R2 hi unchanged by lsb", int'(status), 8'h10);
    wreg("st", 8'h10);
    wreg("hi_h", 8'h00);
    meas(16'h0010);
    check("R2 hi committed", int'(status), 8'h00);
    wreg("lo_l", 8'h20);
    meas(16'h0010);
    check("R2 lo unchanged by lsb", int'(status), 8'h00);
    wreg("lo_h", 8'h00);
    meas(16'h0010);
    check("R2 lo committed", int'(status), 8'h10);
    wreg("st", 8'h10);

    // R3 strict edges (window 0x20..0xFF)
    cur_req = "R3";
    meas(16'h0020); meas(16'h00FF);
    check("R3 edges in range", int'(status), 8'h00);
    meas(16'h0100);
    check("R3 above hi", int'(status), 8'h10);
    wreg("st", 8'h10);
    meas(16'h001F);
    check("R3 below lo", int'(status), 8'h10);
    wreg("st", 8'h10);

    // R5 codes 2 and 3, R7 restart
    cur_req = "R5";
    wreg("pers", 2);
    meas(16'h50);
    meas(16'h300);
    check("R5 code2 one", int'(status), 8'h00);
    meas(16'h300);
    check("R5 code2 two", int'(status), 8'h10);
    wreg("st", 8'h10);
    wreg("pers", 3);
    meas(16'h50);
    cur_req = "R7";
    meas(16'h300); meas(16'h300); meas(16'h50);
    meas(16'h300); meas(16'h300);
    check("R7 restart after in-range", int'(status), 8'h00);
    meas(16'h300);
    check("R5 code3 three", int'(status), 8'h10);

    // R8 sticky and saturated run
    cur_req = "R8";
    meas(16'h50); meas(16'h60);
    check("R8 sticky", int'(status), 8'h10);
    meas(16'h300); meas(16'h300); meas(16'h300);
    wreg("st", 8'h10);
    meas(16'h300);
    check("R8 refire after clear", int'(status), 8'h10);
    wreg("st", 8'h10);

    // R6 codes 4 and 15
    cur_req = "R6";
    wreg("pers", 4);
    meas(16'h50);
    for (int i = 0; i < 4; i++) meas(16'h300);
    check("R6 code4 four", int'(status), 8'h00);
    meas(16'h300);
    check("R6 code4 five", int'(status), 8'h10);
    wreg("st", 8'h10);
    wreg("pers", 15);
    meas(16'h50);
    for (int i = 0; i < 59; i++) meas(16'h300);
    check("R6 code15 fifty-nine", int'(status), 8'h00);
    meas(16'h300);
    check("R6 code15 sixty", int'(status), 8'h10);
    wreg("st", 8'h10);
    meas(16'h50);

    // R11 / R12 saturation and enables
    cur_req = "R11";
    wreg("en", 8'h80);
    meas(16'h50, 1);
    check("R11 sat flag", int'(status), 8'h80);
    cur_req = "R12";
    check("R12 sat int", int'(int_n), 0);
    wreg("pers", 0);
    meas(16'h50);
    wreg("en", 8'h00);
    check("R12 no enables", int'(int_n), 1);
    wreg("en", 8'h10);
    check("R12 thr enable", int'(int_n), 0);
    wreg("st", 8'h80);
    check("R9 clear sat only", int'(status), 8'h10);

    // R10 read-clear
    cur_req = "R10";
    rd_status = 1; tick();
    check("R10 read without option", int'(status), 8'h10);
    wreg("cfg", 8'h80);
    meas(16'h50, 1);
    rd_status = 1; tick();
    check("R10 read clears", int'(status), 8'h00);
    check("R10 int released", int'(int_n), 1);

    // R13 set beats clear
    cur_req = "R13";
    res_valid = 1; res_data = 16'h50; res_sat = 1; rd_status = 1; tick();
    check("R13 set wins", int'(status), 8'h90);
    res_valid = 1; res_data = 16'h50; wr_status = 1; wr_data = 8'h90; tick();
    check("R13 set wins thr", int'(status), 8'h10);

    finish_run();
  end
endmodule